// File: doc/BRIEF.md
# Zero-Overhead Repeat Controller

This block sits next to a simple in-order sequencer and turns a block of straight-line instructions into a loop that costs no branch instructions. A repeat command retires like any other instruction and carries the iteration count, the body length and the issue form. The block then watches the retire stream. Each time the last body instruction retires and iterations remain, it sends the fetch stage back to the first body instruction.

There are two issue forms. The early form acts in pipeline stage 2, so exactly one spacer instruction follows the command. It always executes, and it needs an immediate count. The late form acts in stage 4, so three spacers follow it. It can take its count from a register and can be made conditional. If its condition fails, the body simply runs once in line.

The retire stream carries valid but no ready, because an observer cannot hold back retirement. The command is taken only in a cycle where it is marked and an instruction retires. The redirect is a one-cycle pulse with no back-pressure. The fetch stage must act on it in the cycle it appears.

Top module: `repeat_ctrl`

## Requirements
- R1: An early-form command retiring at address P puts the body start at P+2, which leaves one spacer at P+1. Every redirect goes to P+2. Address arithmetic wraps modulo 2^PC_W.
- R2: A late-form command retiring at address P puts the body start at P+4, which leaves three spacers at P+1 to P+3. A register-sourced count is accepted in this form.
- R3: With count N≥1 and length L≥1, the body end address (start+L-1) retires N times. The block raises redir_valid after each of the first N-1 of those retirements and not after the last one. It raises redir_valid only while busy.
- R4: A body of length 1 with count 128 retires its single instruction 128 times in a row. The block gives 127 consecutive redirects, and busy drops after the 128th retirement.
- R5: redir_valid is high for exactly the cycle after the retirement of the body end instruction, and redir_pc holds the body start address in that cycle.
- R6: A late-form command with cmd_cond=0 does not arm the block: busy stays 0 and the body runs once with no redirect.
- R7: An early-form command arms regardless of cmd_cond.
- R8: An early-form command with cmd_cnt_reg=1 (count from a register) is rejected: busy stays 0 and the body is not repeated.
- R9: A count of 0 or a length of 0 does not arm the block.
- R10: A taken branch (ret_branch=1) retiring while busy cancels the loop, including a branch in a spacer slot. No redirect follows it.
- R11: A new command accepted while busy replaces the old loop's bounds and count.
- R12: After reset, busy and redir_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Retiring instruction is a repeat command |
| cmd_late | input | 1 | Form select: 0 early (stage 2, one spacer), 1 late (stage 4, three spacers) |
| cmd_cond | input | 1 | Condition outcome; only the late form honours it |
| cmd_cnt_reg | input | 1 | Count came from a register rather than an immediate |
| cmd_count | input | CNT_W | Iteration count |
| cmd_len | input | LEN_W | Body length in instructions |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_pc | input | PC_W | Address of the retiring instruction |
| ret_branch | input | 1 | Retiring instruction took a branch |
| redir_valid | output | 1 | Fetch redirect pulse |
| redir_pc | output | PC_W | Redirect target (body start) |
| busy | output | 1 | A loop is armed |

## Verification
Every result is registered once. After a command retires, busy reflects the arming decision in the next cycle. After the body end retires, redir_valid and redir_pc are due in the next cycle, and busy drops in that same cycle on the final pass or after a taken branch. The bench drives each retirement on the falling edge and samples all three outputs 1 ns after the following rising edge. It compares them there against the position in the loop, which it computes from the address, count and length.

// File: rtl/rep_pkg.sv
package rep_pkg;
  typedef enum logic {FORM_EARLY = 1'b0, FORM_LATE = 1'b1} form_e;
  // spacer slots between the command and the first body instruction
  localparam int GAP_EARLY = 1;
  localparam int GAP_LATE  = 3;
endpackage

// File: rtl/rep_bounds.sv
module rep_bounds
  import rep_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int LEN_W = 8
) (
  input  logic [PC_W-1:0]  cmd_pc,
  input  form_e            form,
  input  logic [LEN_W-1:0] len,
  output logic [PC_W-1:0]  body_start,
  output logic [PC_W-1:0]  body_last
);
  localparam logic [PC_W-1:0] OFS_EARLY = PC_W'(GAP_EARLY + 1);
  localparam logic [PC_W-1:0] OFS_LATE  = PC_W'(GAP_LATE + 1);

  logic [PC_W-1:0] len_ext;

  generate
    if (LEN_W < PC_W) begin : g_pad
      assign len_ext = {{(PC_W-LEN_W){1'b0}}, len};
    end else begin : g_trim
      assign len_ext = len[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    body_start = cmd_pc + ((form == FORM_LATE) ? OFS_LATE : OFS_EARLY);
    body_last  = body_start + len_ext - PC_W'(1);
  end
endmodule

// File: rtl/rep_gate.sv
module rep_gate
  import rep_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LEN_W = 8
) (
  input  form_e            form,
  input  logic             cond,
  input  logic             cnt_reg,
  input  logic [CNT_W-1:0] count,
  input  logic [LEN_W-1:0] len,
  output logic             arm_ok
);
  logic form_ok;
  always_comb begin
    // late form honours its condition; early form cannot read a register count
    form_ok = (form == FORM_LATE) ? cond : !cnt_reg;
    arm_ok  = form_ok && (count != '0) && (len != '0);
  end
endmodule

// File: rtl/rep_iter.sv
module rep_iter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             final_pass
);
  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    remain_q <= '0;
    else if (load) remain_q <= load_val;
    else if (dec)  remain_q <= remain_q - CNT_W'(1);
  end

  assign final_pass = (remain_q == CNT_W'(1));
endmodule

// File: rtl/repeat_ctrl.sv
module repeat_ctrl
  import rep_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int CNT_W = 16,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_late,
  input  logic             cmd_cond,
  input  logic             cmd_cnt_reg,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             ret_valid,
  input  logic [PC_W-1:0]  ret_pc,
  input  logic             ret_branch,
  output logic             redir_valid,
  output logic [PC_W-1:0]  redir_pc,
  output logic             busy
);
  form_e           form;
  logic [PC_W-1:0] nxt_start, nxt_last;
  logic            arm_ok, final_pass;
  logic            armed_q, redir_q;
  logic [PC_W-1:0] start_q, last_q, redir_pc_q;
  logic            accept, cancel, at_end;

  assign form = form_e'(cmd_late);

  rep_bounds #(.PC_W(PC_W), .LEN_W(LEN_W)) u_bounds (
    .cmd_pc(ret_pc), .form(form), .len(cmd_len),
    .body_start(nxt_start), .body_last(nxt_last)
  );

  rep_gate #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_gate (
    .form(form), .cond(cmd_cond), .cnt_reg(cmd_cnt_reg),
    .count(cmd_count), .len(cmd_len), .arm_ok(arm_ok)
  );

  always_comb begin
    accept = cmd_valid && ret_valid;
    cancel = !accept && armed_q && ret_valid && ret_branch;
    at_end = !accept && !cancel && armed_q && ret_valid && (ret_pc == last_q);
  end

  rep_iter #(.CNT_W(CNT_W)) u_iter (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(cmd_count),
    .dec(at_end), .final_pass(final_pass)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q    <= 1'b0;
      redir_q    <= 1'b0;
      start_q    <= '0;
      last_q     <= '0;
      redir_pc_q <= '0;
    end else begin
      redir_q <= 1'b0;
      if (accept) begin
        armed_q <= arm_ok;
        start_q <= nxt_start;
        last_q  <= nxt_last;
      end else if (cancel) begin
        armed_q <= 1'b0;
      end else if (at_end) begin
        redir_q    <= !final_pass;
        redir_pc_q <= start_q;
        if (final_pass) armed_q <= 1'b0;
      end
    end
  end

  assign redir_valid = redir_q;
  assign redir_pc    = redir_pc_q;
  assign busy        = armed_q;
endmodule

// File: rtl/rep_ctrl_chk.sv
module rep_ctrl_chk #(
  parameter int CNT_W = 16,
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_late,
  input logic             cmd_cond,
  input logic             cmd_cnt_reg,
  input logic [CNT_W-1:0] cmd_count,
  input logic [LEN_W-1:0] cmd_len,
  input logic             ret_valid,
  input logic             ret_branch,
  input logic             redir_valid,
  input logic             busy
);
  AST_REDIR_AFTER_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> $past(ret_valid && !ret_branch && !cmd_valid)); // R5
  AST_IDLE_NO_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !redir_valid); // R3
  AST_BRANCH_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_branch && !cmd_valid) |=> !busy); // R10
  AST_ZERO_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && ret_valid && (cmd_count == '0 || cmd_len == '0)) |=> !busy); // R9
  AST_CANCELLED_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && ret_valid && cmd_late && !cmd_cond) |=> !busy); // R6
  AST_EARLY_REG_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && ret_valid && !cmd_late && cmd_cnt_reg) |=> !busy); // R8
endmodule

bind repeat_ctrl rep_ctrl_chk #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_late(cmd_late),
  .cmd_cond(cmd_cond), .cmd_cnt_reg(cmd_cnt_reg), .cmd_count(cmd_count),
  .cmd_len(cmd_len), .ret_valid(ret_valid), .ret_branch(ret_branch),
  .redir_valid(redir_valid), .busy(busy)
);

// File: tb/sim_repeat_ctrl.sv
`timescale 1ns/1ps
module sim_repeat_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_late = 1'b0, cmd_cond = 1'b0, cmd_cnt_reg = 1'b0;
  logic [15:0] cmd_count = '0;
  logic [7:0]  cmd_len = '0;
  logic        ret_valid = 1'b0, ret_branch = 1'b0;
  logic [15:0] ret_pc = '0;
  logic        redir_valid, busy;
  logic [15:0] redir_pc;
  int errs = 0;
  int checks = 0;

  always #5 clk = ~clk;

  repeat_ctrl #(.PC_W(16), .CNT_W(16), .LEN_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_late(cmd_late),
    .cmd_cond(cmd_cond), .cmd_cnt_reg(cmd_cnt_reg), .cmd_count(cmd_count),
    .cmd_len(cmd_len), .ret_valid(ret_valid), .ret_pc(ret_pc),
    .ret_branch(ret_branch), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .busy(busy)
  );

  task automatic drive(input logic [15:0] pc, input logic br, input logic cv,
                       input logic late, input logic cond, input logic creg,
                       input logic [15:0] cnt, input logic [7:0] len);
    @(negedge clk);
    ret_valid = 1'b1; ret_pc = pc; ret_branch = br; cmd_valid = cv;
    cmd_late = late; cmd_cond = cond; cmd_cnt_reg = creg;
    cmd_count = cnt; cmd_len = len;
    @(posedge clk);
    #1;
    ret_valid = 1'b0; ret_branch = 1'b0; cmd_valid = 1'b0;
  endtask

  task automatic retire(input logic [15:0] pc, input logic br);
    drive(pc, br, 1'b0, 1'b0, 1'b0, 1'b0, 16'd0, 8'd0);
  endtask

  task automatic expect_out(input string req, input logic ev,
                            input logic [15:0] epc, input logic eb);
    checks++;
    if (redir_valid !== ev || busy !== eb || (ev && redir_pc !== epc)) begin
      errs++;
      $display("FAIL %s: redir=%0b pc=%h busy=%0b expected redir=%0b pc=%h busy=%0b",
               req, redir_valid, redir_pc, busy, ev, epc, eb);
    end
  endtask

  task automatic run_loop(input string req, input logic [15:0] p, input logic late,
                          input logic cond, input logic creg, input int cnt,
                          input int len, input logic armed);
    int gap = late ? 3 : 1;
    logic [15:0] st = p + 16'(gap + 1);
    int iters = (armed && cnt > 0) ? cnt : 1;
    drive(p, 1'b0, 1'b1, late, cond, creg, 16'(cnt), 8'(len));
    expect_out(req, 1'b0, 16'd0, armed);
    for (int s = 1; s <= gap; s++) begin
      retire(p + 16'(s), 1'b0);
      expect_out(req, 1'b0, 16'd0, armed);
    end
    for (int it = 0; it < iters; it++) begin
      for (int k = 0; k < len; k++) begin
        logic lst = (k == len - 1);
        retire(st + 16'(k), 1'b0);
        expect_out(req, armed && lst && (it < iters - 1), st,
                   armed && !(lst && it == iters - 1));
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    expect_out("R12", 1'b0, 16'd0, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    expect_out("R12", 1'b0, 16'd0, 1'b0);

    // R1 / R2 / R3 sweep over form, count and length
    for (int f = 0; f < 2; f++)
      for (int c = 1; c <= 4; c++)
        for (int l = 1; l <= 3; l++)
          run_loop(f ? "R2" : "R1", 16'(16'h0100 + 16'(f * 64 + c * 8 + l)),
                   1'(f), 1'b1, 1'b0, c, l, 1'b1);
    run_loop("R1", 16'hFFFE, 1'b0, 1'b1, 1'b0, 3, 2, 1'b1);   // wraps to 0x0000
    run_loop("R3", 16'h0180, 1'b1, 1'b1, 1'b0, 6, 4, 1'b1);
    run_loop("R4", 16'h0200, 1'b0, 1'b1, 1'b0, 128, 1, 1'b1);
    run_loop("R6", 16'h0220, 1'b1, 1'b0, 1'b0, 3, 2, 1'b0);
    run_loop("R7", 16'h0240, 1'b0, 1'b0, 1'b0, 3, 2, 1'b1);
    run_loop("R8", 16'h0260, 1'b0, 1'b1, 1'b1, 3, 2, 1'b0);
    run_loop("R2", 16'h0280, 1'b1, 1'b1, 1'b1, 3, 2, 1'b1);
    run_loop("R9", 16'h02A0, 1'b0, 1'b1, 1'b0, 0, 2, 1'b0);
    run_loop("R9", 16'h02C0, 1'b1, 1'b1, 1'b0, 4, 0, 1'b0);

    // R10: branch in a spacer slot of a late command
    drive(16'h0300, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'd4, 8'd2);
    expect_out("R10", 1'b0, 16'd0, 1'b1);
    retire(16'h0301, 1'b1);
    expect_out("R10", 1'b0, 16'd0, 1'b0);
    retire(16'h0305, 1'b0);
    expect_out("R10", 1'b0, 16'd0, 1'b0);
    // R10: branch inside the body
    drive(16'h0320, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'd4, 8'd3);
    retire(16'h0321, 1'b0);
    retire(16'h0322, 1'b0);
    retire(16'h0323, 1'b0);
    expect_out("R10", 1'b0, 16'd0, 1'b1);
    retire(16'h0323, 1'b1);
    expect_out("R10", 1'b0, 16'd0, 1'b0);
    retire(16'h0324, 1'b0);
    expect_out("R10", 1'b0, 16'd0, 1'b0);

    // R11: second command replaces an armed loop
    drive(16'h0340, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'd5, 8'd2);
    retire(16'h0341, 1'b0);
    drive(16'h0400, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'd2, 8'd1);
    expect_out("R11", 1'b0, 16'd0, 1'b1);
    retire(16'h0401, 1'b0);
    retire(16'h0343, 1'b0);            // old end address no longer matches
    expect_out("R11", 1'b0, 16'd0, 1'b1);
    retire(16'h0402, 1'b0);
    expect_out("R11", 1'b1, 16'h0402, 1'b1);
    retire(16'h0402, 1'b0);
    expect_out("R11", 1'b0, 16'd0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule